// File: doc/BRIEF.md
# Multi-Pattern Converter Test Generator

This block feeds the transport layer of a multi-converter serial data link with synthetic sample data. Three generators run inside it: a parallel pseudo-random bit sequence, an alternating checkerboard and an incrementing ramp. A run-time mode input picks which of them reaches the output bus. Each beat of the bus carries every sample of every converter for several frames.

The converter count and the samples per frame are fixed at elaboration as maximums. Both can be lowered at run time, and the slots of disabled converters or samples then read as zero. An elaboration parameter mirrors the converter order on the bus. The output uses a valid/ready handshake. Every generator holds its state while the consumer stalls. A change of mode, or a pulse on the restart input, starts the newly selected pattern from its beginning.

Top module: `ctg_pattern_top`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0. From the first rising clock edge after release, `valid_o` is 1 and stays 1.
- R2: Mode 0 is the PRBS pattern with polynomial x^15 + x^14 + 1 and a 15-bit state that resets to all ones. Each step computes the new bit as state[14] XOR state[13], shifts the state left and enters that bit at bit 0. Each sample takes N consecutive new bits, the first one in the sample's MSB. Samples are filled in logical slot order, and the sequence continues across beats.
- R3: Mode 1 is the checkerboard. A sample with an even logical sample index has bit i set exactly when i is even (16'h5555 for N=16). A sample with an odd index is the bitwise complement.
- R4: Mode 2 is the ramp. A sample's value is its logical sample index modulo 2^N.
- R5: The logical sample index of slot (frame f, converter m, sample s) in a beat is K + (f*M_MAX + m)*S_MAX + s. K starts at 0 and grows by FRAMES_PER_CLK*M_MAX*S_MAX on each beat with valid_o and ready_i both high.
- R6: Mode 3 drives the whole data bus to zero.
- R7: When `mode_i` differs from the mode in use, or `restart_i` is high, the beat after the next clock edge shows the selected pattern from index 0 with the PRBS state at its seed. No advance takes place at that edge.
- R8: With REVERSE_LANES=0, slot (f, m, s) sits at bits starting at ((f*M_MAX + m)*S_MAX + s)*N.
- R9: With REVERSE_LANES=1, converter m is placed at position M_MAX-1-m in that layout. The logical index and the data are unchanged.
- R10: Slots with m >= conv_act_i or s >= samp_act_i read as zero. A count above the maximum enables all slots. Hidden slots still consume logical indices.
- R11: While valid_o is high and ready_i is low, and the mode, the restart input and the active counts do not change, data_o stays stable and no generator advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart of the selected generator |
| mode_i | input | 2 | Pattern select: 0 PRBS, 1 checkerboard, 2 ramp, 3 zero |
| conv_act_i | input | $clog2(M_MAX+1) | Number of active converters |
| samp_act_i | input | $clog2(S_MAX+1) | Number of active samples per converter per frame |
| ready_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | Beat on data_o is valid |
| data_o | output | FRAMES_PER_CLK*M_MAX*S_MAX*N | All samples of all converters for FRAMES_PER_CLK frames |

## Verification
Generator state and the mode in use are registered, so an accepted beat, a mode change or a restart shows on data_o one clock edge later. The active counts act on data_o in the same cycle they change, with no edge in between. The bench drives inputs and checks outputs on the falling edge. Its reference steps the sample index and the PRBS state at the rising edge between them, so each comparison covers exactly one edge of update. It checks a default-layout instance and a mirrored instance against the same reference on every cycle.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  typedef enum logic [1:0] {
    PAT_PRBS    = 2'd0,
    PAT_CHECKER = 2'd1,
    PAT_RAMP    = 2'd2,
    PAT_ZERO    = 2'd3
  } pat_mode_e;

  localparam int unsigned LFSR_W = 15;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
endpackage

// File: rtl/ctg_prbs_gen.sv
module ctg_prbs_gen
  import ctg_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter int unsigned P = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           adv_i,
  output logic [P*N-1:0] slots_o
);
  logic [LFSR_W-1:0] state_q, state_d, walk;

  // Unrolled serial walk: N bits per slot, MSB first, slots in order.
  always_comb begin
    walk    = state_q;
    slots_o = '0;
    for (int p = 0; p < int'(P); p++) begin
      for (int b = int'(N) - 1; b >= 0; b--) begin
        logic nb;
        nb = walk[LFSR_W-1] ^ walk[LFSR_W-2];
        walk = {walk[LFSR_W-2:0], nb};
        slots_o[p*N + b] = nb;
      end
    end
  end

  always_comb begin
    if (restart_i)  state_d = LFSR_SEED;
    else if (adv_i) state_d = walk;
    else            state_d = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LFSR_SEED;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ctg_ramp_gen.sv
module ctg_ramp_gen #(
  parameter int unsigned N = 16,
  parameter int unsigned P = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           adv_i,
  output logic [P*N-1:0] slots_o
);
  localparam logic [N-1:0] STEP = N'(P);

  logic [N-1:0] base_q, base_d;

  for (genvar p = 0; p < P; p++) begin : g_slot
    assign slots_o[p*N +: N] = base_q + N'(p);
  end

  always_comb begin
    if (restart_i)  base_d = '0;
    else if (adv_i) base_d = base_q + STEP;
    else            base_d = base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_d;
  end
endmodule

// File: rtl/ctg_chk_gen.sv
module ctg_chk_gen #(
  parameter int unsigned N = 16,
  parameter int unsigned P = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           adv_i,
  output logic [P*N-1:0] slots_o
);
  function automatic logic [N-1:0] even_word();
    logic [N-1:0] w;
    for (int i = 0; i < int'(N); i++) w[i] = (i % 2) == 0;
    return w;
  endfunction

  localparam logic [N-1:0] WORD_EVEN = even_word();
  localparam logic         P_ODD     = P[0];

  logic phase_q, phase_d;

  for (genvar p = 0; p < P; p++) begin : g_slot
    localparam logic SLOT_ODD = p[0];
    assign slots_o[p*N +: N] = (phase_q ^ SLOT_ODD) ? ~WORD_EVEN : WORD_EVEN;
  end

  always_comb begin
    if (restart_i)  phase_d = 1'b0;
    else if (adv_i) phase_d = phase_q ^ P_ODD;
    else            phase_d = phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/ctg_lane_map.sv
module ctg_lane_map #(
  parameter int unsigned N              = 16,
  parameter int unsigned M_MAX          = 2,
  parameter int unsigned S_MAX          = 2,
  parameter int unsigned FRAMES_PER_CLK = 2,
  parameter bit          REVERSE_LANES  = 1'b0,
  localparam int unsigned CW = $clog2(M_MAX + 1),
  localparam int unsigned SW = $clog2(S_MAX + 1),
  localparam int unsigned W  = FRAMES_PER_CLK * M_MAX * S_MAX * N
) (
  input  logic [W-1:0]  slots_i,
  input  logic [CW-1:0] conv_act_i,
  input  logic [SW-1:0] samp_act_i,
  output logic [W-1:0]  data_o
);
  for (genvar f = 0; f < FRAMES_PER_CLK; f++) begin : g_frame
    for (genvar m = 0; m < M_MAX; m++) begin : g_conv
      localparam int unsigned MPOS = REVERSE_LANES ? (M_MAX - 1 - m) : m;
      for (genvar s = 0; s < S_MAX; s++) begin : g_samp
        localparam int unsigned LIDX = (f * M_MAX + m) * S_MAX + s;
        localparam int unsigned PIDX = (f * M_MAX + MPOS) * S_MAX + s;
        logic on;
        assign on = (int'(conv_act_i) > m) && (int'(samp_act_i) > s);
        assign data_o[PIDX*N +: N] = on ? slots_i[LIDX*N +: N] : '0;
      end
    end
  end
endmodule

// File: rtl/ctg_pattern_top.sv
module ctg_pattern_top
  import ctg_pkg::*;
#(
  parameter int unsigned N              = 16,
  parameter int unsigned M_MAX          = 2,
  parameter int unsigned S_MAX          = 2,
  parameter int unsigned FRAMES_PER_CLK = 2,
  parameter bit          REVERSE_LANES  = 1'b0,
  localparam int unsigned CW = $clog2(M_MAX + 1),
  localparam int unsigned SW = $clog2(S_MAX + 1),
  localparam int unsigned P  = FRAMES_PER_CLK * M_MAX * S_MAX,
  localparam int unsigned W  = P * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] conv_act_i,
  input  logic [SW-1:0] samp_act_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [W-1:0]  data_o
);
  pat_mode_e mode_q, mode_d;
  logic      valid_q, valid_d;
  logic      restart, adv;
  logic [W-1:0] prbs_slots, chk_slots, ramp_slots, sel_slots;

  always_comb begin
    restart = (mode_i != mode_q) || restart_i;
    adv     = valid_q && ready_i && !restart;
    mode_d  = pat_mode_e'(mode_i);
    valid_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= PAT_PRBS;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

  ctg_prbs_gen #(.N(N), .P(P)) u_prbs (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .adv_i(adv), .slots_o(prbs_slots)
  );
  ctg_chk_gen #(.N(N), .P(P)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .adv_i(adv), .slots_o(chk_slots)
  );
  ctg_ramp_gen #(.N(N), .P(P)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .adv_i(adv), .slots_o(ramp_slots)
  );

  always_comb begin
    unique case (mode_q)
      PAT_PRBS:    sel_slots = prbs_slots;
      PAT_CHECKER: sel_slots = chk_slots;
      PAT_RAMP:    sel_slots = ramp_slots;
      default:     sel_slots = '0;
    endcase
  end

  ctg_lane_map #(
    .N(N), .M_MAX(M_MAX), .S_MAX(S_MAX),
    .FRAMES_PER_CLK(FRAMES_PER_CLK), .REVERSE_LANES(REVERSE_LANES)
  ) u_map (
    .slots_i(sel_slots), .conv_act_i(conv_act_i), .samp_act_i(samp_act_i), .data_o(data_o)
  );

  assign valid_o = valid_q;
endmodule

// File: rtl/ctg_pattern_sva.sv
module ctg_pattern_sva #(
  parameter int unsigned N              = 16,
  parameter int unsigned M_MAX          = 2,
  parameter int unsigned S_MAX          = 2,
  parameter int unsigned FRAMES_PER_CLK = 2,
  parameter bit          REVERSE_LANES  = 1'b0,
  localparam int unsigned CW = $clog2(M_MAX + 1),
  localparam int unsigned SW = $clog2(S_MAX + 1),
  localparam int unsigned W  = FRAMES_PER_CLK * M_MAX * S_MAX * N
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          restart_i,
  input logic [1:0]    mode_i,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] conv_act_i,
  input logic [SW-1:0] samp_act_i,
  input logic          ready_i,
  input logic          valid_o,
  input logic [W-1:0]  data_o
);
  localparam logic [N-1:0] FIRST_RAMP = REVERSE_LANES ? N'((M_MAX - 1) * S_MAX) : '0;

  logic full;
  assign full = (int'(conv_act_i) >= int'(M_MAX)) && (int'(samp_act_i) >= int'(S_MAX));

  p_valid_stays_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !restart_i && mode_i == mode_q)
    |=> (!($stable(conv_act_i) && $stable(samp_act_i)) || $stable(data_o)));

  p_zero_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd3) |-> (data_o == '0));

  p_no_conv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_act_i == '0 || samp_act_i == '0) |-> (data_o == '0));

  p_ramp_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && mode_q != 2'd2)
    |=> (!full || data_o[N-1:0] == FIRST_RAMP));

  p_checker_alt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1 && full) |-> ((data_o[N-1:0] ^ data_o[2*N-1:N]) == '1));
endmodule

bind ctg_pattern_top ctg_pattern_sva #(
  .N(N), .M_MAX(M_MAX), .S_MAX(S_MAX),
  .FRAMES_PER_CLK(FRAMES_PER_CLK), .REVERSE_LANES(REVERSE_LANES)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .mode_i(mode_i),
  .mode_q(mode_q), .conv_act_i(conv_act_i), .samp_act_i(samp_act_i),
  .ready_i(ready_i), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/ctg_pattern_top_test.sv
`timescale 1ns/1ps
module ctg_pattern_top_test;
  localparam int N = 16, M = 2, S = 2, F = 2;
  localparam int P = F * M * S;
  localparam int W = P * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] conv_act = 2'd2;
  logic [1:0] samp_act = 2'd2;
  logic ready = 1'b1;
  logic valid_a, valid_b;
  logic [W-1:0] data_a, data_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  int          m_mode = 0;
  int          m_k = 0;
  logic [14:0] m_prbs = 15'h7FFF;
  bit          m_valid = 0;

  always #4 clk = ~clk;

  ctg_pattern_top #(.N(N), .M_MAX(M), .S_MAX(S), .FRAMES_PER_CLK(F), .REVERSE_LANES(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .mode_i(mode),
    .conv_act_i(conv_act), .samp_act_i(samp_act), .ready_i(ready),
    .valid_o(valid_a), .data_o(data_a));

  ctg_pattern_top #(.N(N), .M_MAX(M), .S_MAX(S), .FRAMES_PER_CLK(F), .REVERSE_LANES(1'b1)) uut_rev (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .mode_i(mode),
    .conv_act_i(conv_act), .samp_act_i(samp_act), .ready_i(ready),
    .valid_o(valid_b), .data_o(data_b));

  function automatic logic [W-1:0] model_data(bit rev);
    logic [W-1:0] d;
    logic [14:0]  st;
    logic [N-1:0] smp;
    d  = '0;
    st = m_prbs;
    for (int f = 0; f < F; f++)
      for (int m = 0; m < M; m++)
        for (int s = 0; s < S; s++) begin
          int idx, mm;
          idx = m_k + (f * M + m) * S + s;
          smp = '0;
          case (m_mode)
            0: for (int b = N - 1; b >= 0; b--) begin
                 logic nb;
                 nb = st[14] ^ st[13];
                 st = {st[13:0], nb};
                 smp[b] = nb;
               end
            1: for (int i = 0; i < N; i++) smp[i] = ((i % 2) == 0) ^ (idx % 2 == 1);
            2: smp = N'(idx);
            default: smp = '0;
          endcase
          mm = rev ? (M - 1 - m) : m;
          if (m < int'(conv_act) && s < int'(samp_act))
            d[((f * M + mm) * S + s) * N +: N] = smp;
        end
    return d;
  endfunction

  task automatic compare(string tag);
    logic [W-1:0] ea, eb;
    ea = model_data(1'b0);
    eb = model_data(1'b1);
    checks++;
    if (valid_a !== m_valid || valid_b !== m_valid) begin
      failures++;
      $display("FAIL %s/R1 valid=%b/%b exp=%b", tag, valid_a, valid_b, m_valid);
    end
    checks++;
    if (data_a !== ea) begin
      failures++;
      $display("FAIL %s/R8 uut data=%h exp=%h", tag, data_a, ea);
    end
    checks++;
    if (data_b !== eb) begin
      failures++;
      $display("FAIL %s/R9 uut_rev data=%h exp=%h", tag, data_b, eb);
    end
  endtask

  // Drive at falling edge, model the rising edge, check at the next falling edge.
  task automatic cyc(string tag, int md, bit rdy, int ca, int sa, bit rs);
    bit rst_gen;
    mode = 2'(md); ready = rdy; conv_act = 2'(ca); samp_act = 2'(sa); restart = rs;
    #1;
    compare({tag, "-pre"});
    rst_gen = (md != m_mode) || rs;
    @(posedge clk);
    if (rst_gen) begin
      m_mode = md; m_k = 0; m_prbs = 15'h7FFF;
    end else if (m_valid && rdy) begin
      m_k += P;
      for (int i = 0; i < P * N; i++) m_prbs = {m_prbs[13:0], m_prbs[14] ^ m_prbs[13]};
    end
    m_valid = 1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // R2: PRBS across beats, R8/R9 layouts
    for (int i = 0; i < 6; i++) cyc("R2", 0, 1, 2, 2, 0);
    // R7 into checkerboard, then R3
    cyc("R7", 1, 1, 2, 2, 0);
    for (int i = 0; i < 5; i++) cyc("R3", 1, 1, 2, 2, 0);
    // R4 ramp, R5 index stepping, R11 stalls
    cyc("R7", 2, 1, 2, 2, 0);
    for (int i = 0; i < 12; i++) cyc((i % 3 == 1) ? "R11" : "R5", 2, (i % 3) != 1, 2, 2, 0);
    for (int i = 0; i < 4; i++) cyc("R11", 2, 0, 2, 2, 0);
    cyc("R4", 2, 1, 2, 2, 0);
    // R10 downscaling
    cyc("R10", 2, 1, 1, 1, 0);
    cyc("R10", 2, 1, 1, 2, 0);
    cyc("R10", 2, 1, 2, 1, 0);
    cyc("R10", 2, 1, 3, 3, 0);
    cyc("R10", 2, 1, 0, 2, 0);
    cyc("R10", 2, 0, 2, 0, 0);
    // R7 synchronous restart in the same mode
    cyc("R7", 2, 1, 2, 2, 1);
    cyc("R7", 2, 1, 2, 2, 0);
    // R6 zero pattern
    for (int i = 0; i < 3; i++) cyc("R6", 3, 1, 2, 2, 0);
    // back to PRBS with irregular ready and counts
    for (int i = 0; i < 40; i++) cyc("R2", 0, ($urandom % 4) != 0, 1 + ($urandom % 3), 1 + ($urandom % 2), 0);
    for (int i = 0; i < 10; i++) cyc("R3", 1, ($urandom % 2) == 1, 2, 2, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule